// File: doc/BRIEF.md
# DRAM Page-Mode Column Read Sequencer

This block drives the control strobes and multiplexed address of an asynchronous DRAM to read several words from one row while opening that row only once. A request carries a row, a starting column, a length and a column-advance discipline. The sequencer places the row on the address pins and drops the row strobe. It then performs one column access per word and closes the row after the final word has been taken.

Three column-advance disciplines are supported. In page mode the column strobe is pulsed for every word and a new column is presented while it is high. In static-column mode the column strobe stays low and each new column address is itself the start of the next access. In nibble mode the column strobe is pulsed again and the memory steps to the next location inside an aligned group of four, so only the first column address matters.

Requests use a valid/ready handshake: a request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the request fields are sampled only on that edge. Words leave through a valid/ready stream with one register stage. Once `rsp_valid` is high, `rsp_data` and `rsp_last` hold until `rsp_ready` is seen high. While the stage is full the pending column access is stretched, so no word is lost. All timing values are whole clock cycles and must satisfy T_RCD >= 1, T_CAC >= 2, T_PC >= T_CAC + 1 and T_RC >= 3.

Top module: `colseq_reader`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low. A request is accepted on an edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle after an acceptance.
- R2: `ras_n` falls on the first edge after acceptance, with the row on `addr` from the acceptance edge on. It stays low until the row is closed.
- R3: The first `cas_n` fall comes exactly T_RCD+1 edges after the `ras_n` fall. The start column is on `addr` and `oe_n` is low one cycle before that fall.
- R4: Page mode (`req_mode` 0, and also 3) reads columns start, start+1, ... modulo 2^COL_W. `cas_n` rises after each word that is not the last, and the next column is on `addr` while `cas_n` is high. Successive `cas_n` falls are at least T_PC cycles apart, and exactly T_PC when the output is never stalled.
- R5: Static-column mode (`req_mode` 1) reads the same column order as page mode. `cas_n` stays low from its first fall until the row closes, and each later access starts with a change of `addr`, at least T_PC cycles (exactly T_PC when unstalled) after the previous access start.
- R6: Nibble mode (`req_mode` 2) delivers min(len+1, 4) words. Word k comes from the start column with its two low bits replaced by (low bits + k) mod 4, and each later word is started by a new `cas_n` fall at least T_PC cycles after the last one.
- R7: Each word is the value on `dq_in` sampled T_CAC edges after the start of its access. Words leave in column order, and the request delivers len+1 words (page and static modes).
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_last` hold. A word is neither dropped nor repeated under back-pressure.
- R9: `rsp_last` is high on the final word of a request only. `ras_n`, `cas_n` and `oe_n` all go high on the edge that captures that word.
- R10: Two `ras_n` falls are at least T_RC cycles apart, and `req_ready` stays low until that spacing can be met.
- R11: Changes on `req_mode`, `req_row`, `req_col` and `req_len` after acceptance have no effect on the request in flight.
- R12: After reset `ras_n`, `cas_n` and `oe_n` are high, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Start column |
| req_len | input | COL_W | Word count minus one |
| req_mode | input | 2 | 0/3 page, 1 static-column, 2 nibble |
| busy | output | 1 | Access or row-cycle recovery in progress |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dq_in | input | DATA_W | Read data from the memory |
| rsp_valid | output | 1 | Word available |
| rsp_ready | input | 1 | Consumer takes the word |
| rsp_data | output | DATA_W | Word read |
| rsp_last | output | 1 | Final word of the request |

## Verification
The capture of a fresh word and the hand-off of the previous word to the consumer can fall on the same edge. In that case the output stage must be refilled in the very cycle it empties. The bench provokes this by driving `rsp_ready` high on about 70% of cycles while requests of random length and mode stream back to back. A cycle-level memory model returns a location-dependent pattern only when the strobe timing is right. Every delivered word is compared in order against a queue built from the requirements, and words held under back-pressure are checked for stability, so a lost, doubled or early-sampled word shows up as a data mismatch.

// File: rtl/colseq_pkg.sv
package colseq_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [1:0] CM_PAGE   = 2'd0;
  localparam logic [1:0] CM_STATIC = 2'd1;
  localparam logic [1:0] CM_NIBBLE = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RCD,
    ST_COL,
    ST_ACC,
    ST_GAP
  } seq_state_t;
endpackage

// File: rtl/colseq_downcnt.sv
module colseq_downcnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/colseq_colstep.sv
module colseq_colstep #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] col_i,
  input  logic             nibble_i,
  output logic [COL_W-1:0] col_o
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    if (nibble_i) col_o = {col_i[COL_W-1:2], col_i[1:0] + 2'd1};
    else          col_o = col_i + COL_W'(1);
  end
endmodule

// File: rtl/colseq_outslot.sv
module colseq_outslot #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_last,
  output logic              free,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);
  timeunit 1ns;
  timeprecision 1ps;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
      out_last  <= load_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign free = !out_valid || out_ready;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !load |=> !out_valid);
endmodule

// File: rtl/colseq_reader.sv
module colseq_reader
  import colseq_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 3,
  parameter int T_CAC  = 3,
  parameter int T_PC   = 7,
  parameter int T_RC   = 22,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [COL_W-1:0]  req_len,
  input  logic [1:0]        req_mode,
  output logic              busy,
  output logic              ras_n,
  output logic              cas_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LEFT_W = COL_W + 1;
  localparam int CNT_W  = $clog2(T_RC + T_PC + T_RCD + T_CAC + 1);

  seq_state_t        state_q;
  logic [1:0]        mode_q;
  logic [COL_W-1:0]  col_q, col_nxt;
  logic [LEFT_W-1:0] left_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ras_q, cas_q, oe_q;

  logic rc_zero, pc_zero, cac_zero;
  logic row_open, acc_start, cac_load, slot_free, capture, last_word;
  logic is_static, is_nib, fire;
  logic [CNT_W-1:0] cac_val;

  assign is_static = (mode_q == CM_STATIC);
  assign is_nib    = (mode_q == CM_NIBBLE);

  assign busy      = (state_q != ST_IDLE) || !rc_zero;
  assign req_ready = !busy;
  assign fire      = req_valid && req_ready;

  assign row_open  = (state_q == ST_ROW);
  assign acc_start = (state_q == ST_COL) || ((state_q == ST_GAP) && pc_zero);
  assign cac_load  = row_open || acc_start;
  assign cac_val   = row_open ? CNT_W'(T_RCD - 1) : CNT_W'(T_CAC - 1);

  assign last_word = (left_q == LEFT_W'(1));
  assign capture   = (state_q == ST_ACC) && cac_zero && slot_free;

  // row-cycle recovery, started on the row strobe fall
  colseq_downcnt #(.W(CNT_W)) u_rc (
    .clk(clk), .rst_n(rst_n), .load(row_open),
    .load_val(CNT_W'(T_RC - 2)), .zero(rc_zero));

  // spacing between column access starts
  colseq_downcnt #(.W(CNT_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .load(acc_start),
    .load_val(CNT_W'(T_PC - 1)), .zero(pc_zero));

  // row-to-column delay, then column-to-data delay
  colseq_downcnt #(.W(CNT_W)) u_cac (
    .clk(clk), .rst_n(rst_n), .load(cac_load),
    .load_val(cac_val), .zero(cac_zero));

  colseq_colstep #(.COL_W(COL_W)) u_step (
    .col_i(col_q), .nibble_i(is_nib), .col_o(col_nxt));

  colseq_outslot #(.DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(capture), .load_data(dq_in),
    .load_last(last_word), .free(slot_free), .out_valid(rsp_valid),
    .out_ready(rsp_ready), .out_data(rsp_data), .out_last(rsp_last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= CM_PAGE;
      col_q   <= '0;
      left_q  <= '0;
      addr_q  <= '0;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
      oe_q    <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (fire) begin
          mode_q <= req_mode;
          col_q  <= req_col;
          addr_q <= ADDR_W'(req_row);
          if (req_mode == CM_NIBBLE && req_len > COL_W'(3)) left_q <= LEFT_W'(4);
          else                                            left_q <= LEFT_W'(req_len) + LEFT_W'(1);
          state_q <= ST_ROW;
        end
        ST_ROW: begin
          ras_q   <= 1'b0;
          state_q <= ST_RCD;
        end
        ST_RCD: if (cac_zero) begin
          addr_q  <= ADDR_W'(col_q);
          oe_q    <= 1'b0;
          state_q <= ST_COL;
        end
        ST_COL: begin
          cas_q   <= 1'b0;
          state_q <= ST_ACC;
        end
        ST_ACC: if (capture) begin
          left_q <= left_q - LEFT_W'(1);
          if (last_word) begin
            ras_q   <= 1'b1;
            cas_q   <= 1'b1;
            oe_q    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            col_q <= col_nxt;
            if (!is_static) cas_q <= 1'b1;
            if (!is_static && !is_nib) addr_q <= ADDR_W'(col_nxt);
            state_q <= ST_GAP;
          end
        end
        ST_GAP: if (pc_zero) begin
          if (is_static) addr_q <= ADDR_W'(col_q);
          else           cas_q  <= 1'b0;
          state_q <= ST_ACC;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ras_n = ras_q;
  assign cas_n = cas_q;
  assign oe_n  = oe_q;
  assign addr  = addr_q;

  p_row_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> busy);

  p_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> rsp_valid && rsp_last && cas_n && oe_n);

  p_static_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_static && state_q == ST_GAP |-> !cas_n);

  p_nib_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_nib && state_q != ST_IDLE |-> left_q <= LEFT_W'(4));

  p_rc_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rc_zero |-> !req_ready);

  p_first_cas_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_COL |=> !cas_n && !oe_n && !ras_n);
endmodule

// File: tb/tb_colseq_reader.sv
module tb_colseq_reader;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ROW_W = 10, COL_W = 8, DATA_W = 16;
  localparam int T_RCD = 3, T_CAC = 3, T_PC = 7, T_RC = 22;
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam logic [DATA_W-1:0] JUNK = 16'hDEAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0, req_len = '0;
  logic [1:0] req_mode = '0;
  logic busy, ras_n, cas_n, oe_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dq = JUNK;
  logic rsp_valid, rsp_last;
  logic rsp_ready = 1'b1;
  logic [DATA_W-1:0] rsp_data;

  int tests = 0, fails = 0;
  bit all_ready = 1'b1;

  always #2.5 clk = ~clk;

  colseq_reader #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_CAC(T_CAC), .T_PC(T_PC), .T_RC(T_RC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_len(req_len), .req_mode(req_mode),
    .busy(busy), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n), .addr(addr),
    .dq_in(dq), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_last(rsp_last));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
    return DATA_W'((32'(r) * 32'd131) ^ (32'(c) * 32'd7) ^ 32'h5A3C);
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [COL_W-1:0] c0, input logic [1:0] m, input int k);
    if (m == 2'd2) return {c0[COL_W-1:2], c0[1:0] + 2'(k)};
    return c0 + COL_W'(k);
  endfunction

  function automatic int words_of(input logic [COL_W-1:0] l, input logic [1:0] m);
    if (m == 2'd2 && l > 3) return 4;
    return int'(l) + 1;
  endfunction

  logic [DATA_W-1:0] exp_d[$];
  bit                exp_l[$];

  // cycle-level memory model with strobe timing checks
  int cyc = 0, t_acc = 0, t_ras = -1000, t_last = 0, age = 0;
  logic [1:0] m_mode = '0;
  logic [ROW_W-1:0] m_row = '0;
  logic [COL_W-1:0] m_col = '0;
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  logic [ADDR_W-1:0] prev_addr = '0;
  bit m_first = 1'b0;

  always @(posedge clk) begin
    bit strobe;
    if (!rst_n) begin
      prev_ras = 1'b1; prev_cas = 1'b1; age = 0;
      dq <= JUNK;
    end else begin
      cyc++;
      strobe = 1'b0;
      if (req_valid && req_ready) begin
        t_acc  = cyc;
        m_mode = req_mode;
        for (int k = 0; k < words_of(req_len, req_mode); k++) begin
          exp_d.push_back(pat(req_row, col_of(req_col, req_mode, k)));
          exp_l.push_back(k == words_of(req_len, req_mode) - 1);
        end
      end
      if (!ras_n && prev_ras) begin
        chk(cyc - t_acc == 2, "R2 row strobe one edge after accept", 32'(cyc - t_acc), 32'd2);
        chk(cyc - t_ras >= T_RC, "R10 row cycle spacing", 32'(cyc - t_ras), 32'(T_RC));
        t_ras = cyc;
        m_row = ROW_W'(prev_addr);
        m_first = 1'b1;
      end
      if (!ras_n && !cas_n && prev_cas) begin
        if (m_first) begin
          chk(cyc - t_ras == T_RCD + 1, "R3 first column strobe delay", 32'(cyc - t_ras), 32'(T_RCD + 1));
          m_col = COL_W'(prev_addr);
          m_first = 1'b0;
          t_last = cyc;
          strobe = 1'b1;
        end else if (m_mode == 2'd1) begin
          chk(1'b0, "R5 column strobe re-pulsed in static mode", 32'(cyc), 32'd0);
        end else begin
          if (m_mode == 2'd2) m_col = {m_col[COL_W-1:2], m_col[1:0] + 2'd1};
          else                m_col = COL_W'(prev_addr);
          strobe = 1'b1;
        end
      end
      if (m_mode == 2'd1 && !ras_n && cas_n && !prev_cas)
        chk(1'b0, "R5 column strobe rose with row open", 32'(cyc), 32'd0);
      if (m_mode == 2'd1 && !ras_n && !cas_n && !prev_cas && addr != prev_addr) begin
        m_col = COL_W'(addr);
        strobe = 1'b1;
      end
      if (strobe && cyc != t_last) begin
        chk(cyc - t_last >= T_PC, "R4 access spacing minimum", 32'(cyc - t_last), 32'(T_PC));
        if (all_ready)
          chk(cyc - t_last == T_PC, "R4 R5 unstalled access spacing", 32'(cyc - t_last), 32'(T_PC));
        t_last = cyc;
      end
      if (strobe) age = 1; else age++;
      dq <= (!ras_n && !cas_n && !oe_n && age >= T_CAC - 1) ? pat(m_row, m_col) : JUNK;
      prev_ras = ras_n; prev_cas = cas_n; prev_addr = addr;
    end
  end

  // response consumer and scoreboard
  bit held = 1'b0;
  logic [DATA_W-1:0] held_d = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held)
        chk(rsp_valid && rsp_data == held_d, "R8 held word stable", 32'(rsp_data), 32'(held_d));
      rsp_ready = all_ready ? 1'b1 : (($urandom % 10) < 7);
      held = rsp_valid && !rsp_ready;
      held_d = rsp_data;
      if (rsp_valid && rsp_ready) begin
        if (exp_d.size() == 0) begin
          chk(1'b0, "R7 unexpected word", 32'(rsp_data), 32'd0);
        end else begin
          logic [DATA_W-1:0] ed;
          bit el;
          ed = exp_d.pop_front();
          el = exp_l.pop_front();
          chk(rsp_data == ed, "R7 R6 word data and order", 32'(rsp_data), 32'(ed));
          chk(rsp_last == el, "R9 last flag", 32'(rsp_last), 32'(el));
        end
      end
    end
  end

  task automatic send(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c,
                      input logic [COL_W-1:0] l, input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_row = r; req_col = c; req_len = l; req_mode = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    req_mode = 2'($urandom); req_row = ROW_W'($urandom);
    req_col = COL_W'($urandom); req_len = COL_W'($urandom);   // R11 scramble
    @(negedge clk);
    chk(!req_ready && busy, "R1 not ready after accept", 32'(req_ready), 32'd0);
  endtask

  task automatic drain();
    int guard = 0;
    @(negedge clk);
    while ((exp_d.size() != 0 || busy || rsp_valid) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(exp_d.size() == 0, "R7 all words delivered", 32'(exp_d.size()), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(ras_n && cas_n && oe_n, "R12 strobes high in reset", {29'd0, ras_n, cas_n, oe_n}, 32'd7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid, "R12 no word after reset", 32'(rsp_valid), 32'd0);
    chk(req_ready && !busy, "R12 R1 ready after reset", 32'(req_ready), 32'd1);

    all_ready = 1'b1;
    send(10'd5,   8'd254, 8'd3, 2'd0);   // R4 page wrap 254,255,0,1
    send(10'd9,   8'd255, 8'd2, 2'd1);   // R5 static wrap 255,0,1
    send(10'd700, 8'd6,   8'd7, 2'd2);   // R6 nibble cap 6,7,4,5
    send(10'd33,  8'd17,  8'd0, 2'd0);   // single word
    send(10'd64,  8'd3,   8'd2, 2'd3);   // code 3 acts as page
    send(10'd2,   8'd12,  8'd1, 2'd2);   // nibble shorter than 4
    drain();

    all_ready = 1'b0;
    send(10'd511, 8'd0, 8'd255, 2'd1);   // full row, static
    for (int i = 0; i < 40; i++) begin
      send(ROW_W'($urandom), COL_W'($urandom), COL_W'($urandom % 12), 2'($urandom % 4));
    end
    drain();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule